// File: doc/BRIEF.md
# Color Lookup Palette with Selectable Resolution

The block is a color lookup table that turns a pixel index into red, green and blue codes for three 8-bit DAC inputs. A host port loads and reads the table one component at a time, and the pixel side reads it at the same time through a second read port. A control register sets the color resolution. In 6-bit resolution, host data is shifted into the upper bits of each stored component, and the lower bits are cleared. In 8-bit resolution, host data passes through unchanged.

The same control register can force the DAC outputs to zero. Blanking does not stop the lookup pipeline. A 24-bit signature register is fed from the values taken before blanking, so software can confirm that the pipeline kept running while the screen was dark. The host uses a 2-bit register select. Select 0 is the table address, 1 is the component data, 2 is control and 3 is the signature clear. The signature is shown on its own output.

Top module: `clut_palette`

## Requirements
- R1: While `rst` is high and after its release, the DAC outputs, `sig_value` and `host_rdata` are zero, and a read of the control register returns 0x00 (6-bit resolution, unblanked).
- R2: With control bit 2 clear (6-bit resolution), a data write stores `host_wdata[5:0]` in component bits [7:2] and zero in bits [1:0]. Write data bits [7:6] are ignored.
- R3: With control bit 2 clear, a data read returns component bits [7:2] on `host_rdata[5:0]`, with `host_rdata[7:6]` zero.
- R4: With control bit 2 set (8-bit resolution), data writes and reads move all eight bits unchanged.
- R5: The DAC outputs carry the stored component bits unchanged in both resolutions. In 6-bit resolution, bits [1:0] come from the stored entry.
- R6: Data accesses step through red, green and blue. The entry is committed on the blue write. The address increments after any blue access and wraps from 255 to 0. Writing the address register sets it and restarts at red.
- R7: The DAC outputs show the entry at `pix_idx` two rising edges after the index is presented.
- R8: While control bit 4 is set, all DAC outputs are zero. One edge after bit 4 clears, the outputs show the current pipeline value.
- R9: On each edge where a valid pixel reaches the output stage, the signature becomes `{s[22:0], s[23]^s[22]^s[21]^s[16]} ^ {r,g,b}`. This uses the values from before blanking, so it also happens while the outputs are blanked. Otherwise the signature holds. A write to select 3 clears it.
- R10: Control bit 3 always reads back 0 and ignores writes. The other seven control bits read back as written.
- R11: Host read data appears on `host_rdata` two rising edges after the read strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 address, 1 data, 2 control, 3 signature clear |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| pix_valid | input | 1 | Marks `pix_idx` as a pixel for the signature |
| pix_idx | input | 8 | Pixel index into the table |
| dac_red | output | 8 | Red DAC code |
| dac_grn | output | 8 | Green DAC code |
| dac_blu | output | 8 | Blue DAC code |
| sig_value | output | 24 | Signature register |

## Verification
The bench builds the block with its defaults: 256 entries and 8-bit components. Address 255 is therefore a reachable boundary, so the bench can test the wrap to 0 directly. It can also observe the full 6-bit shift, with its two cleared low bits, in both the host readback and the DAC outputs. With a 24-bit signature, the bench can compute the expected value after blanked pixel runs, and it can test that the signature holds and clears.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int CTRL_RES8_BIT  = 2;
  localparam int CTRL_RSVD_BIT  = 3;
  localparam int CTRL_BLANK_BIT = 4;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_SIG  = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } comp_phase_e;
endpackage

// File: rtl/clut_ctrl.sv
module clut_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q,
  output logic         res8,
  output logic         blank
);
  import clut_pkg::*;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == CTRL_RSVD_BIT) begin : g_rsvd
      assign ctrl_q[b] = 1'b0;
    end else begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)        ctrl_q[b] <= 1'b0;
        else if (wr_en) ctrl_q[b] <= wdata[b];
      end
    end
  end

  assign res8  = ctrl_q[CTRL_RES8_BIT];
  assign blank = ctrl_q[CTRL_BLANK_BIT];
endmodule

// File: rtl/clut_store.sv
module clut_store #(
  parameter int IDX_W = 8,
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] host_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [IDX_W-1:0] pix_addr,
  output logic [WIDTH-1:0] q_host,
  output logic [WIDTH-1:0] q_pix
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[host_addr] <= wr_data;
    q_host <= mem[host_addr];
  end

  always_ff @(posedge clk) begin
    q_pix <= mem[pix_addr];
  end
endmodule

// File: rtl/clut_host_port.sv
module clut_host_port #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  we,
  input  logic [1:0]            reg_sel,
  input  logic [COMP_W-1:0]     wdata,
  input  logic                  res8,
  input  logic [COMP_W-1:0]     ctrl_q,
  input  logic [3*COMP_W-1:0]   q_host,
  output logic [IDX_W-1:0]      addr,
  output logic                  wr_en,
  output logic [3*COMP_W-1:0]   wr_entry,
  output logic                  ctrl_wr,
  output logic                  sig_clr,
  output logic [COMP_W-1:0]     rdata
);
  import clut_pkg::*;

  localparam int LOW_W = COMP_W - 6;

  comp_phase_e phase;
  logic [COMP_W-1:0] red_s, grn_s, comp_in, comp_rd, rd_mux;
  logic addr_wr, data_acc, last;

  logic              rd_pend, rd_res8;
  host_sel_e         rd_reg;
  comp_phase_e       rd_phase;
  logic [IDX_W-1:0]  rd_addr;
  logic [COMP_W-1:0] rd_ctrl;

  assign addr_wr  = sel && we && (host_sel_e'(reg_sel) == SEL_ADDR);
  assign data_acc = sel && (host_sel_e'(reg_sel) == SEL_DATA);
  assign ctrl_wr  = sel && we && (host_sel_e'(reg_sel) == SEL_CTRL);
  assign sig_clr  = sel && we && (host_sel_e'(reg_sel) == SEL_SIG);
  assign last     = (phase == PH_BLU);

  // host write alignment per resolution
  assign comp_in  = res8 ? wdata : {wdata[5:0], {LOW_W{1'b0}}};
  assign wr_en    = data_acc && we && last;
  assign wr_entry = {red_s, grn_s, comp_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      phase <= PH_RED;
      red_s <= '0;
      grn_s <= '0;
    end else if (addr_wr) begin
      addr  <= wdata[IDX_W-1:0];
      phase <= PH_RED;
    end else if (data_acc) begin
      case (phase)
        PH_RED:  phase <= PH_GRN;
        PH_GRN:  phase <= PH_BLU;
        default: phase <= PH_RED;
      endcase
      if (last) addr <= addr + 1'b1;
      if (we && phase == PH_RED) red_s <= comp_in;
      if (we && phase == PH_GRN) grn_s <= comp_in;
    end
  end

  // read pipeline: stage 1 captures context, stage 2 forms data
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      rd_res8  <= 1'b0;
      rd_reg   <= SEL_ADDR;
      rd_phase <= PH_RED;
      rd_addr  <= '0;
      rd_ctrl  <= '0;
      rdata    <= '0;
    end else begin
      rd_pend  <= sel && !we;
      rd_res8  <= res8;
      rd_reg   <= host_sel_e'(reg_sel);
      rd_phase <= phase;
      rd_addr  <= addr;
      rd_ctrl  <= ctrl_q;
      if (rd_pend) rdata <= rd_mux;
    end
  end

  always_comb begin
    case (rd_phase)
      PH_RED:  comp_rd = q_host[3*COMP_W-1:2*COMP_W];
      PH_GRN:  comp_rd = q_host[2*COMP_W-1:COMP_W];
      default: comp_rd = q_host[COMP_W-1:0];
    endcase
  end

  always_comb begin
    case (rd_reg)
      SEL_ADDR: rd_mux = COMP_W'(rd_addr);
      SEL_DATA: rd_mux = rd_res8 ? comp_rd
                                 : {{LOW_W{1'b0}}, comp_rd[COMP_W-1:LOW_W]};
      SEL_CTRL: rd_mux = rd_ctrl;
      default:  rd_mux = '0;
    endcase
  end

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !addr_wr && phase == PH_BLU) |=> (addr == IDX_W'($past(addr) + 1'b1)));

  // R6
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (phase == PH_RED && addr == $past(wdata[IDX_W-1:0])));

  // R6
  phase_legal_chk: assert property (@(posedge clk) disable iff (rst)
    phase != comp_phase_e'(2'd3));
endmodule

// File: rtl/clut_misr.sv
module clut_misr #(
  parameter int             W    = 24,
  parameter logic [W-1:0]   TAPS = 24'hE10000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  always_ff @(posedge clk) begin
    if (rst || clr) sig <= '0;
    else if (en)    sig <= {sig[W-2:0], ^(sig & TAPS)} ^ din;
  end

  // R9
  sig_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(sig));
endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_we,
  input  logic [1:0]        host_reg,
  input  logic [COMP_W-1:0] host_wdata,
  output logic [COMP_W-1:0] host_rdata,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [COMP_W-1:0] dac_red,
  output logic [COMP_W-1:0] dac_grn,
  output logic [COMP_W-1:0] dac_blu,
  output logic [3*COMP_W-1:0] sig_value
);
  localparam int ENTRY_W = 3 * COMP_W;

  logic [COMP_W-1:0]  ctrl_q;
  logic               res8, blank, ctrl_wr, sig_clr, wr_en, valid_d1;
  logic [IDX_W-1:0]   addr;
  logic [ENTRY_W-1:0] wr_entry, q_host, q_pix;

  clut_ctrl #(.W(COMP_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(ctrl_wr), .wdata(host_wdata),
    .ctrl_q(ctrl_q), .res8(res8), .blank(blank)
  );

  clut_host_port #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_host (
    .clk(clk), .rst(rst), .sel(host_sel), .we(host_we), .reg_sel(host_reg),
    .wdata(host_wdata), .res8(res8), .ctrl_q(ctrl_q), .q_host(q_host),
    .addr(addr), .wr_en(wr_en), .wr_entry(wr_entry), .ctrl_wr(ctrl_wr),
    .sig_clr(sig_clr), .rdata(host_rdata)
  );

  clut_store #(.IDX_W(IDX_W), .WIDTH(ENTRY_W)) u_store (
    .clk(clk), .wr_en(wr_en), .host_addr(addr), .wr_data(wr_entry),
    .pix_addr(pix_idx), .q_host(q_host), .q_pix(q_pix)
  );

  clut_misr #(.W(ENTRY_W)) u_misr (
    .clk(clk), .rst(rst), .clr(sig_clr), .en(valid_d1),
    .din(q_pix), .sig(sig_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_d1 <= 1'b0;
      dac_red  <= '0;
      dac_grn  <= '0;
      dac_blu  <= '0;
    end else begin
      valid_d1 <= pix_valid;
      dac_red  <= blank ? '0 : q_pix[ENTRY_W-1:2*COMP_W];
      dac_grn  <= blank ? '0 : q_pix[2*COMP_W-1:COMP_W];
      dac_blu  <= blank ? '0 : q_pix[COMP_W-1:0];
    end
  end

  // R8
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    blank |=> (dac_red == '0 && dac_grn == '0 && dac_blu == '0));
endmodule

// File: tb/clut_palette_bench.sv
module clut_palette_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [1:0]  host_reg = 2'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = 8'd0;
  logic [7:0]  dac_red, dac_grn, dac_blu;
  logic [23:0] sig_value;

  int checks = 0, failures = 0;
  logic [23:0] sig_model;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clut_palette u_clut_palette (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
    .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_valid(pix_valid), .pix_idx(pix_idx), .dac_red(dac_red),
    .dac_grn(dac_grn), .dac_blu(dac_blu), .sig_value(sig_value)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] misr_step(input logic [23:0] s, input logic [23:0] d);
    return {s[22:0], s[23] ^ s[22] ^ s[21] ^ s[16]} ^ d;
  endfunction

  task automatic host_wr(input logic [1:0] r, input logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b1; host_reg = r; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] r, output logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b0; host_reg = r;
    @(negedge clk);
    host_sel = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic write_entry(input logic [7:0] a, input logic [7:0] r,
                             input logic [7:0] g, input logic [7:0] b);
    host_wr(2'd0, a); host_wr(2'd1, r); host_wr(2'd1, g); host_wr(2'd1, b);
  endtask

  task automatic read_entry(input logic [7:0] a, output logic [23:0] e);
    logic [7:0] r, g, b;
    host_wr(2'd0, a); host_rd(2'd1, r); host_rd(2'd1, g); host_rd(2'd1, b);
    e = {r, g, b};
  endtask

  task automatic look(input logic [7:0] idx);
    pix_idx = idx;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 dac during reset", {dac_red, dac_grn, dac_blu}, 0);
    check("R1 sig during reset", sig_value, 0);
    check("R1 rdata during reset", host_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    host_rd(2'd2, d);
    check("R1 ctrl after reset", d, 8'h00);
    check("R1 sig after reset", sig_value, 0);
  endtask

  task automatic t_six_bit();
    logic [23:0] e;
    write_entry(8'd5, 8'hFF, 8'hD5, 8'h6A);
    read_entry(8'd5, e);
    check("R3 6-bit readback", e, 24'h3F152A);
    host_wr(2'd2, 8'h04);
    read_entry(8'd5, e);
    check("R2 6-bit stored alignment", e, 24'hFC54A8);
    look(8'd5);
    check("R5 dac after 6-bit write", {dac_red, dac_grn, dac_blu}, 24'hFC54A8);
  endtask

  task automatic t_eight_bit();
    logic [23:0] e;
    write_entry(8'd9, 8'h81, 8'h7E, 8'h03);
    read_entry(8'd9, e);
    check("R4 8-bit readback", e, 24'h817E03);
    host_wr(2'd2, 8'h00);
    read_entry(8'd9, e);
    check("R3 6-bit read of 8-bit entry", e, 24'h201F00);
    look(8'd9);
    check("R5 dac low bits in 6-bit mode", {dac_red, dac_grn, dac_blu}, 24'h817E03);
  endtask

  task automatic t_sequence();
    logic [7:0] d;
    logic [23:0] e;
    host_wr(2'd2, 8'h04);
    write_entry(8'h10, 8'h01, 8'h02, 8'h03);
    host_wr(2'd1, 8'h04); host_wr(2'd1, 8'h05); host_wr(2'd1, 8'h06);
    host_rd(2'd0, d);
    check("R6 address after two entries", d, 8'h12);
    read_entry(8'h11, e);
    check("R6 auto-increment second entry", e, 24'h040506);
    host_wr(2'd0, 8'h20); host_wr(2'd1, 8'h11);
    write_entry(8'h20, 8'h22, 8'h33, 8'h44);
    read_entry(8'h20, e);
    check("R6 address write restarts at red", e, 24'h223344);
    write_entry(8'hFF, 8'hAA, 8'hBB, 8'hCC);
    host_sel = 1'b1; host_we = 1'b0; host_reg = 2'd0;
    @(negedge clk);
    host_sel = 1'b0;
    check("R11 rdata not yet updated after one edge", host_rdata, 8'h44);
    @(negedge clk);
    check("R6 wrap 255 to 0", host_rdata, 8'h00);
    read_entry(8'hFF, e);
    check("R6 entry at 255", e, 24'hAABBCC);
  endtask

  task automatic t_latency();
    look(8'd9);
    pix_idx = 8'd5;
    @(negedge clk);
    check("R7 one edge still old entry", {dac_red, dac_grn, dac_blu}, 24'h817E03);
    @(negedge clk);
    check("R7 two edges new entry", {dac_red, dac_grn, dac_blu}, 24'hFC54A8);
  endtask

  task automatic t_blank_sig();
    host_wr(2'd3, 8'h00);
    sig_model = 24'h0;
    check("R9 clear", sig_value, 0);
    host_wr(2'd2, 8'h14);
    pix_idx = 8'd5; pix_valid = 1'b1;
    @(negedge clk);
    pix_idx = 8'd9;
    @(negedge clk);
    check("R8 blanked output 1", {dac_red, dac_grn, dac_blu}, 0);
    pix_idx = 8'd5;
    @(negedge clk);
    check("R8 blanked output 2", {dac_red, dac_grn, dac_blu}, 0);
    pix_valid = 1'b0; pix_idx = 8'd9;
    repeat (2) @(negedge clk);
    sig_model = misr_step(sig_model, 24'hFC54A8);
    sig_model = misr_step(sig_model, 24'h817E03);
    sig_model = misr_step(sig_model, 24'hFC54A8);
    check("R9 signature while blanked", sig_value, sig_model);
    check("R8 still blanked", {dac_red, dac_grn, dac_blu}, 0);
    repeat (3) @(negedge clk);
    check("R9 signature holds without valid", sig_value, sig_model);
    host_wr(2'd2, 8'h04);
    @(negedge clk);
    check("R8 unblank shows current pipeline", {dac_red, dac_grn, dac_blu}, 24'h817E03);
    host_wr(2'd3, 8'h00);
    check("R9 clear by select 3", sig_value, 0);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    host_wr(2'd2, 8'hFF);
    host_rd(2'd2, d);
    check("R10 reserved bit reads zero", d, 8'hF7);
    host_wr(2'd2, 8'h08);
    host_rd(2'd2, d);
    check("R10 reserved-only write", d, 8'h00);
    host_wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_six_bit();
    t_eight_bit();
    t_sequence();
    t_latency();
    t_blank_sig();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule